// File: doc/BRIEF.md
# Multi-Locality Access Arbiter

The block decides which of five numbered localities owns a shared command interface. Each locality has an access-status byte that can be written and read back. A locality-select register chooses which locality a host write refers to. Locality 4 is kept for hardware and is written through a separate port of its own. Software asks for ownership with a request write, takes ownership by force with a seize write, and gives ownership up by writing the active bit. A higher-numbered locality may seize the interface from a lower-numbered owner. A lower-numbered locality can only queue a request. When the owner releases, the highest-numbered locality that is waiting becomes the owner.

The arbiter drives every locality's status byte in parallel and a one-hot vector of the active locality. The command data path uses that vector as a gate.

Top module: `loc_arbiter`

## Requirements
- R1: After reset the locality select is 0, no locality is active (`active_oh_o` is 0), and every status byte reads 0x81.
- R2: A select write with a value below 5 loads the locality select. A select write with a value of 5 or more is ignored and the old value is kept.
- R3: A host write goes to the locality selected before that clock edge. A host write while locality 4 is selected is ignored. A hardware-port write always targets locality 4, and it wins over a host write in the same cycle, which is then dropped.
- R4: A request write (bit 1 set) while no locality is active makes the writer the owner. Its byte then shows the active bit (bit 5), and its bit in `active_oh_o` is set. At most one locality is active at any time.
- R5: A request write from a non-owner while another locality is active sets the writer's request bit (bit 1). The pending bit (bit 2) of every locality is set exactly when some other locality has a waiting request. The owner never holds a request of its own.
- R6: A seize write (bit 3 set) from a locality with a number not above the owner's leaves the ownership unchanged.
- R7: A seize write from a locality with a higher number than the owner, or from any locality while none is active, makes the writer the owner and clears its request bit. A previous owner loses the active bit and sets its been-seized bit (bit 4).
- R8: A write with bit 4 set clears the writer's been-seized bit.
- R9: An owner write with bit 5 set releases ownership. The highest-numbered locality with a waiting request becomes the owner and its request bit clears. If no request is waiting, no locality is active.
- R10: A bit-5 write from a locality that is not the owner has no effect.
- R11: In one written byte, the seize bit takes priority over the release bit, and the release bit takes priority over the request bit. The bits that lose are ignored.
- R12: In every status byte, bits 7 (register valid) and 0 (establishment) always read 1, and bits 3 and 6 always read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sel_wr_i | input | 1 | Write strobe for the locality select |
| sel_data_i | input | 8 | Value for the locality select |
| host_wr_i | input | 1 | Host write strobe to the selected locality's status byte |
| host_data_i | input | 8 | Host write byte |
| hw_wr_i | input | 1 | Hardware write strobe to locality 4 |
| hw_data_i | input | 8 | Hardware write byte |
| sel_o | output | 3 | Current locality select |
| access_o | output | 40 | Status bytes, locality n at bits [8n+7:8n] |
| active_oh_o | output | 5 | One-hot active locality, 0 when idle |

## Verification
All state sits in registers that load on the write edge, so every result of a write can be seen on the outputs one cycle later: the select value, the ownership, and each status byte. The bench drives a write at a falling edge and lets the next rising edge take it. It then compares sel_o, active_oh_o and all five bytes against its own model at the following falling edge, before any new stimulus is driven. A select write issued together with a host write is modelled as taking effect only after that host write, which matches the one-cycle register on the select.

// File: rtl/loc_arb_pkg.sv
package loc_arb_pkg;
  localparam int B_EST    = 0;
  localparam int B_REQ    = 1;
  localparam int B_PEND   = 2;
  localparam int B_SEIZE  = 3;
  localparam int B_SEIZED = 4;
  localparam int B_ACT    = 5;
  localparam int B_VALID  = 7;
endpackage

// File: rtl/loc_sel_reg.sv
module loc_sel_reg #(
  parameter int NUM_LOC = 5,
  parameter int LW      = $clog2(NUM_LOC)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_i,
  input  logic [7:0]    data_i,
  output logic [LW-1:0] sel_o
);
  logic [LW-1:0] sel_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                                  sel_q <= '0;
    else if (wr_i && (32'(data_i) < NUM_LOC))     sel_q <= data_i[LW-1:0];
  end

  assign sel_o = sel_q;

  p_sel_range_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    32'(sel_q) < NUM_LOC);
  p_sel_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && 32'(data_i) >= NUM_LOC) |=> $stable(sel_q));
endmodule

// File: rtl/loc_owner.sv
module loc_owner
  import loc_arb_pkg::*;
#(
  parameter int NUM_LOC = 5,
  parameter int LW      = $clog2(NUM_LOC)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               wr_i,
  input  logic [LW-1:0]      wl_i,
  input  logic [7:0]         wd_i,
  output logic [NUM_LOC-1:0] req_o,
  output logic [NUM_LOC-1:0] seized_o,
  output logic [NUM_LOC-1:0] act_oh_o
);
  logic               own_v_q, own_v_n;
  logic [LW-1:0]      own_q, own_n;
  logic [NUM_LOC-1:0] req_q, req_n, seized_q, seized_n;
  logic [LW-1:0]      hi_req;

  // highest-numbered waiting requester
  always_comb begin
    hi_req = '0;
    for (int i = 0; i < NUM_LOC; i++)
      if (req_q[i]) hi_req = LW'(i);
  end

  always_comb begin
    own_v_n  = own_v_q;
    own_n    = own_q;
    req_n    = req_q;
    seized_n = seized_q;
    if (wr_i) begin
      if (wd_i[B_SEIZED]) seized_n[wl_i] = 1'b0;
      if (wd_i[B_SEIZE]) begin
        if (!own_v_q || wl_i > own_q) begin
          if (own_v_q) seized_n[own_q] = 1'b1;
          own_v_n     = 1'b1;
          own_n       = wl_i;
          req_n[wl_i] = 1'b0;
        end
      end else if (wd_i[B_ACT]) begin
        if (own_v_q && wl_i == own_q) begin
          if (|req_q) begin
            own_n         = hi_req;
            req_n[hi_req] = 1'b0;
          end else begin
            own_v_n = 1'b0;
          end
        end
      end else if (wd_i[B_REQ]) begin
        if (!own_v_q) begin
          own_v_n = 1'b1;
          own_n   = wl_i;
        end else if (wl_i != own_q) begin
          req_n[wl_i] = 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      own_v_q  <= 1'b0;
      own_q    <= '0;
      req_q    <= '0;
      seized_q <= '0;
    end else begin
      own_v_q  <= own_v_n;
      own_q    <= own_n;
      req_q    <= req_n;
      seized_q <= seized_n;
    end
  end

  for (genvar g = 0; g < NUM_LOC; g++) begin : g_oh
    assign act_oh_o[g] = own_v_q && (own_q == LW'(g));
  end

  assign req_o    = req_q;
  assign seized_o = seized_q;

  p_onehot_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(act_oh_o));
  p_no_self_req_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    own_v_q |-> !req_q[own_q]);
  p_low_seize_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && wd_i[B_SEIZE] && own_v_q && wl_i <= own_q) |=> (own_v_q && $stable(own_q)));
  p_seize_take_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && wd_i[B_SEIZE] && own_v_q && wl_i > own_q) |=> (own_v_q && own_q == $past(wl_i)));
  p_rel_idle_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && !wd_i[B_SEIZE] && wd_i[B_ACT] && own_v_q && wl_i == own_q && req_q == '0)
    |=> !own_v_q);
endmodule

// File: rtl/loc_status_fmt.sv
module loc_status_fmt
  import loc_arb_pkg::*;
#(
  parameter int NUM_LOC = 5
) (
  input  logic [NUM_LOC-1:0]   req_i,
  input  logic [NUM_LOC-1:0]   seized_i,
  input  logic [NUM_LOC-1:0]   act_oh_i,
  output logic [NUM_LOC*8-1:0] access_o
);
  for (genvar g = 0; g < NUM_LOC; g++) begin : g_byte
    logic [NUM_LOC-1:0] others;
    logic [7:0]         b;
    assign others = req_i & ~(NUM_LOC'(1) << g);
    always_comb begin
      b           = '0;
      b[B_VALID]  = 1'b1;
      b[B_EST]    = 1'b1;
      b[B_REQ]    = req_i[g];
      b[B_PEND]   = |others;
      b[B_SEIZED] = seized_i[g];
      b[B_ACT]    = act_oh_i[g];
    end
    assign access_o[g*8 +: 8] = b;
  end
endmodule

// File: rtl/loc_arbiter.sv
module loc_arbiter
  import loc_arb_pkg::*;
#(
  parameter int NUM_LOC = 5,
  parameter int LW      = $clog2(NUM_LOC)
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 sel_wr_i,
  input  logic [7:0]           sel_data_i,
  input  logic                 host_wr_i,
  input  logic [7:0]           host_data_i,
  input  logic                 hw_wr_i,
  input  logic [7:0]           hw_data_i,
  output logic [LW-1:0]        sel_o,
  output logic [NUM_LOC*8-1:0] access_o,
  output logic [NUM_LOC-1:0]   active_oh_o
);
  localparam logic [LW-1:0] HW_LOC = LW'(NUM_LOC - 1);

  logic [LW-1:0]      sel;
  logic               wr;
  logic [LW-1:0]      wl;
  logic [7:0]         wd;
  logic [NUM_LOC-1:0] req, seized, act_oh;

  loc_sel_reg #(.NUM_LOC(NUM_LOC), .LW(LW)) i_sel (
    .clk_i, .rst_ni, .wr_i(sel_wr_i), .data_i(sel_data_i), .sel_o(sel)
  );

  // hardware port wins; host may not reach the hardware locality
  always_comb begin
    if (hw_wr_i) begin
      wr = 1'b1;
      wl = HW_LOC;
      wd = hw_data_i;
    end else begin
      wr = host_wr_i && (sel != HW_LOC);
      wl = sel;
      wd = host_data_i;
    end
  end

  loc_owner #(.NUM_LOC(NUM_LOC), .LW(LW)) i_own (
    .clk_i, .rst_ni, .wr_i(wr), .wl_i(wl), .wd_i(wd),
    .req_o(req), .seized_o(seized), .act_oh_o(act_oh)
  );

  loc_status_fmt #(.NUM_LOC(NUM_LOC)) i_fmt (
    .req_i(req), .seized_i(seized), .act_oh_i(act_oh), .access_o(access_o)
  );

  assign sel_o       = sel;
  assign active_oh_o = act_oh;

  p_host_hw_blocked_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (host_wr_i && !hw_wr_i && sel == HW_LOC) |=> $stable(access_o[(NUM_LOC-1)*8 +: 8]));
endmodule

// File: tb/test_loc_arbiter.sv
`timescale 1ns/1ps
module test_loc_arbiter;
  localparam int N = 5;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sel_wr = 1'b0, host_wr = 1'b0, hw_wr = 1'b0;
  logic [7:0]  sel_d = '0, host_d = '0, hw_d = '0;
  logic [2:0]  sel_o;
  logic [N*8-1:0] access;
  logic [N-1:0]   act_oh;

  int errors = 0, checks = 0;
  bit done = 0;

  bit m_req[N], m_seized[N];
  bit m_own_v;
  int m_own, m_sel;

  always #2 clk = ~clk;

  loc_arbiter i_loc_arbiter (
    .clk_i(clk), .rst_ni(rst_n),
    .sel_wr_i(sel_wr), .sel_data_i(sel_d),
    .host_wr_i(host_wr), .host_data_i(host_d),
    .hw_wr_i(hw_wr), .hw_data_i(hw_d),
    .sel_o(sel_o), .access_o(access), .active_oh_o(act_oh)
  );

  function automatic logic [7:0] exp_byte(int l);
    logic [7:0] b = 8'h81;
    bit pend = 0;
    for (int k = 0; k < N; k++) if (k != l && m_req[k]) pend = 1;
    b[1] = m_req[l];
    b[2] = pend;
    b[4] = m_seized[l];
    b[5] = m_own_v && (m_own == l);
    return b;
  endfunction

  task automatic model_wr(int wl, logic [7:0] d);
    int hi = -1;
    if (d[4]) m_seized[wl] = 0;
    if (d[3]) begin
      if (!m_own_v || wl > m_own) begin
        if (m_own_v) m_seized[m_own] = 1;
        m_own_v = 1; m_own = wl; m_req[wl] = 0;
      end
    end else if (d[5]) begin
      if (m_own_v && wl == m_own) begin
        for (int k = 0; k < N; k++) if (m_req[k]) hi = k;
        if (hi >= 0) begin m_own = hi; m_req[hi] = 0; end
        else m_own_v = 0;
      end
    end else if (d[1]) begin
      if (!m_own_v) begin m_own_v = 1; m_own = wl; end
      else if (wl != m_own) m_req[wl] = 1;
    end
  endtask

  task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic check_all(string tag);
    logic [N-1:0] eoh = '0;
    if (m_own_v) eoh[m_own] = 1'b1;
    chk({tag, " sel R2"}, 64'(sel_o), 64'(m_sel));
    chk({tag, " active R4"}, 64'(act_oh), 64'(eoh));
    for (int l = 0; l < N; l++)
      chk($sformatf("%s byte%0d R12", tag, l), 64'(access[l*8 +: 8]), 64'(exp_byte(l)));
  endtask

  // drive at falling edge, take at rising edge, check at next falling edge
  task automatic step(bit sw, logic [7:0] sd, bit hw, logic [7:0] hd,
                      bit xw, logic [7:0] xd, string tag);
    sel_wr = sw; sel_d = sd; host_wr = hw; host_d = hd; hw_wr = xw; hw_d = xd;
    @(posedge clk);
    if (xw) model_wr(4, xd);
    else if (hw && m_sel != 4) model_wr(m_sel, hd);
    if (sw && sd < N) m_sel = sd;
    @(negedge clk);
    sel_wr = 0; host_wr = 0; hw_wr = 0;
    check_all(tag);
  endtask

  task automatic wr_loc(int l, logic [7:0] d, string tag);
    if (l == 4) step(0, 0, 0, 0, 1, d, tag);
    else begin
      if (m_sel != l) step(1, 8'(l), 0, 0, 0, 0, tag);
      step(0, 0, 1, d, 0, 0, tag);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog R1: actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    for (int l = 0; l < N; l++) begin m_req[l] = 0; m_seized[l] = 0; end
    m_own_v = 0; m_own = 0; m_sel = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check_all("R1 reset");

    step(1, 8'd5, 0, 0, 0, 0, "R2 sel5 ignored");
    step(1, 8'd3, 0, 0, 0, 0, "R2 sel3");
    step(1, 8'd200, 0, 0, 0, 0, "R2 sel200 ignored");

    wr_loc(1, 8'h02, "R4 grant idle");
    wr_loc(0, 8'h02, "R5 queue");
    wr_loc(0, 8'h08, "R6 low seize");
    wr_loc(1, 8'h08, "R6 self seize");
    wr_loc(2, 8'h08, "R7 seize high");
    wr_loc(1, 8'h10, "R8 clear seized");
    wr_loc(3, 8'h02, "R5 second req");
    wr_loc(0, 8'h20, "R10 nonowner release");
    wr_loc(2, 8'h20, "R9 pass highest");
    chk("R9 owner is 3", 64'(act_oh), 64'h08);
    wr_loc(3, 8'h20, "R9 pass to 0");
    wr_loc(0, 8'h20, "R9 idle");
    chk("R9 none active", 64'(act_oh), 64'h00);

    step(1, 8'd4, 0, 0, 0, 0, "R3 sel4");
    step(0, 0, 1, 8'h02, 0, 0, "R3 host to hw loc ignored");
    chk("R3 still idle", 64'(act_oh), 64'h00);
    step(1, 8'd1, 0, 0, 0, 0, "R3 sel1");
    step(0, 0, 1, 8'h02, 1, 8'h02, "R3 hw wins");
    chk("R3 hw owner", 64'(act_oh), 64'h10);
    wr_loc(4, 8'h20, "R9 hw release idle");

    wr_loc(2, 8'h2A, "R11 seize beats rel req");
    chk("R11 bits3 6 zero", 64'(access[2*8 +: 8] & 8'h48), 64'h00);
    wr_loc(2, 8'h22, "R11 rel beats req");
    chk("R11 idle after rel", 64'(act_oh), 64'h00);

    for (int i = 0; i < 600; i++) begin
      int r = $urandom_range(0, 9);
      logic [7:0] d;
      case ($urandom_range(0, 5))
        0: d = 8'h02;
        1: d = 8'h08;
        2: d = 8'h20;
        3: d = 8'h10;
        default: d = 8'($urandom);
      endcase
      if (r < 2) step(1, 8'($urandom_range(0, 7)), 0, 0, 0, 0, "R2 rand sel");
      else if (r < 4) step(0, 0, 0, 0, 1, d, "R3 rand hw");
      else if (r < 5) step(1, 8'($urandom_range(0, 7)), 1, d, $urandom_range(0, 1) == 1, 8'($urandom), "R3 rand mix");
      else step(0, 0, 1, d, 0, 0, "R5 rand host");
    end

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule